// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block models the command side of a byte-wide parallel NOR flash. A host drives chip-enable, write-enable and output-enable strobes, an address and a data byte. The block samples those strobes on its own clock. It decodes the multi-write unlock sequences that start a program, a sector erase, a chip erase, an unlock-bypass session or an erase suspend and resume. It then runs the selected operation against a small internal byte array.

While an operation is in progress, the block returns a status byte instead of array data. A per-sector protect vector keeps program and erase away from locked sectors. A low-supply input makes every write cycle count for nothing. Program and erase durations come from cycle counters rather than cell physics.

The array uses a top-boot sector map. The address range is cut into 64 equal units of `UNIT_BYTES` bytes each. Seven large sectors of 8 units sit at the bottom, then one sector of 4 units, two sectors of 1 unit each, and one sector of 2 units at the top. With the default of 32 bytes per unit, the array holds 2048 bytes on 11 address bits.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset every array byte reads 0xFF, and reads return array data with DQ6 unchanged between two reads (no operation in progress).
- R2: The four writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then data D at address A start a program. After PGM_CYCLES clocks the byte at A becomes old AND D, so a program can only clear bits.
- R3: While a program runs, a read returns bit 7 as the complement of bit 7 of D. While an erase (including its queue window) runs, a read returns bit 7 as 0. In both cases bits 5..0 read as 0, and bit 6 inverts after every completed read. When the operation ends, reads return array data again.
- R4: The writes 0xAA@0x555, 0x55@0x2AA, 0x20@0x555 enter bypass mode. In bypass mode, 0xA0 at any address followed by data D at address A programs A. A write other than 0xA0 in bypass mode leaves bypass mode for read mode.
- R5: The sector index is taken from unit u = address / UNIT_BYTES, top-boot order:
  - u = 0..55 gives sector u/8 (0..6);
  - u = 56..59 gives sector 7;
  - u = 60 gives sector 8;
  - u = 61 gives sector 9;
  - u = 62..63 gives sector 10.
- R6: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x30@A select the sector of A for erase. Each further 0x30 write before EWIN_CYCLES clocks have passed adds the sector of its address and restarts the window. When the erase ends, selected sectors read 0xFF and other sectors are unchanged.
- R7: The same erase prefix closed by 0x10@0x555 erases every unprotected sector to 0xFF without a queue window.
- R8: A sector whose bit in prot_i is 1 is never changed by program or erase. A program aimed at it starts no operation, so a read straight after returns array data.
- R9: While lowv_i is 1, write cycles have no effect on the command sequence, the array or any operation.
- R10: During an erase, 0xB0 at any address suspends it. While suspended:
  - sectors not selected for erase read array data and accept the four-write program;
  - a read of a selected sector returns 1 on bit 7, 0 on bits 5..0, and bit 6 does not change;
  - 0x30 at any address resumes the erase.
- R11: A write that does not match the next expected cycle of a sequence returns the decoder to read mode, so later fragments of the sequence start nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; a write is taken when it rises |
| oe_ni | input | 1 | Output enable, active low |
| lowv_i | input | 1 | Low-supply indication; blocks all writes while 1 |
| prot_i | input | 11 | Per-sector protect flags, bit n guards sector n |
| addr_i | input | AW (11) | Byte address |
| data_i | input | 8 | Write data / command byte |
| data_o | output | 8 | Read data or status byte; 0 when not output-enabled |

## Verification
A write takes effect at the first clock edge that samples write-enable high again, so the bench checks state only after its write task has returned. A program lands PGM_CYCLES edges after its last write. A sector erase starts EWIN_CYCLES edges after its last 0x30, and a chip erase starts at once. The erase sweep then takes two passes of the array, 2×DEPTH edges. Status is checked within a few cycles of the starting write, well inside those windows. Final values are read only after a fixed margin past the due edge. Every read is sampled at a falling clock edge while output-enable has been low for a full cycle, and the toggle bit moves only when output-enable rises.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam int NSECT = 11;
  localparam logic [10:0] UNLK_A1 = 11'h555;
  localparam logic [10:0] UNLK_A2 = 11'h2AA;
  localparam logic [7:0] CMD_U1   = 8'hAA;
  localparam logic [7:0] CMD_U2   = 8'h55;
  localparam logic [7:0] CMD_PGM  = 8'hA0;
  localparam logic [7:0] CMD_ESET = 8'h80;
  localparam logic [7:0] CMD_BYP  = 8'h20;
  localparam logic [7:0] CMD_CHIP = 8'h10;
  localparam logic [7:0] CMD_SECT = 8'h30;
  localparam logic [7:0] CMD_SUSP = 8'hB0;

  typedef enum logic [2:0] {OP_IDLE, OP_PGM, OP_EWIN, OP_ERS, OP_SUSP, OP_SPGM} op_e;
  typedef enum logic [3:0] {
    SQ_RD, SQ_U1, SQ_U2, SQ_PG, SQ_E1, SQ_E2, SQ_E3, SQ_BYP, SQ_BPG
  } seq_e;

  // top-boot map: 7 x 8 units, then 4, 1, 1, 2 units
  function automatic logic [3:0] sect_of_unit(input logic [5:0] u);
    if (u < 6'd56)       return {1'b0, u[5:3]};
    else if (u < 6'd60)  return 4'd7;
    else if (u == 6'd60) return 4'd8;
    else if (u == 6'd61) return 4'd9;
    else                 return 4'd10;
  endfunction
endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map #(
  parameter int UNIT_BYTES = 32,
  localparam int AW = $clog2(UNIT_BYTES) + 6
) (
  input  logic [AW-1:0] addr_i,
  output logic [3:0]    sect_o
);
  import flash_pkg::*;
  assign sect_o = sect_of_unit(addr_i[AW-1 -: 6]);
endmodule

// File: rtl/flash_bus_sync.sv
module flash_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic wr_stb_o,
  output logic rd_end_o
);
  logic ce_q, we_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q <= 1'b1;
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      ce_q <= ce_ni;
      we_q <= we_ni;
      oe_q <= oe_ni;
    end
  end

  assign wr_stb_o = ~we_q & we_ni & ~ce_q;
  assign rd_end_o = ~oe_q & oe_ni & ~ce_q;
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_pkg::*;
#(
  parameter int UNIT_BYTES  = 32,
  parameter int PGM_CYCLES  = 20,
  parameter int EWIN_CYCLES = 64,
  localparam int AW    = $clog2(UNIT_BYTES) + 6,
  localparam int CMAX  = (PGM_CYCLES > EWIN_CYCLES) ? PGM_CYCLES : EWIN_CYCLES,
  localparam int CW    = $clog2(CMAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stb_i,
  input  logic             lowv_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       data_i,
  input  logic [3:0]       sect_i,
  input  logic [3:0]       sweep_sect_i,
  input  logic [NSECT-1:0] prot_i,
  input  logic [7:0]       pgm_old_i,
  output op_e              op_o,
  output logic [NSECT-1:0] mask_o,
  output logic             pgm_d7_o,
  output logic [AW-1:0]    pa_o,
  output logic [AW-1:0]    ptr_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_wa_o,
  output logic [7:0]       mem_wd_o
);
  seq_e             seq_q;
  op_e              op_q;
  logic [CW-1:0]    cnt_q;
  logic [AW-1:0]    ptr_q, pa_q;
  logic             phase_q;
  logic [NSECT-1:0] mask_q;
  logic [7:0]       pd_q;

  logic stb, is_a1, is_a2, pgm_ok, pgm_done;
  logic [NSECT-1:0] sel;

  assign stb    = wr_stb_i & ~lowv_i;
  assign is_a1  = addr_i[10:0] == UNLK_A1;
  assign is_a2  = addr_i[10:0] == UNLK_A2;
  assign sel    = NSECT'(1) << sect_i;
  assign pgm_ok = !prot_i[sect_i] && (op_q == OP_IDLE || !mask_q[sect_i]);
  assign pgm_done = (op_q == OP_PGM || op_q == OP_SPGM) && cnt_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q   <= SQ_RD;
      op_q    <= OP_IDLE;
      cnt_q   <= '0;
      ptr_q   <= '0;
      phase_q <= 1'b0;
      mask_q  <= '0;
      pa_q    <= '0;
      pd_q    <= 8'hFF;
    end else begin
      unique case (op_q)
        OP_PGM, OP_SPGM: begin
          if (cnt_q == '0) op_q <= (op_q == OP_PGM) ? OP_IDLE : OP_SUSP;
          else             cnt_q <= cnt_q - 1'b1;
        end
        OP_EWIN: begin
          if (stb) begin
            if (data_i == CMD_SECT) begin
              mask_q <= mask_q | (sel & ~prot_i);
              cnt_q  <= CW'(EWIN_CYCLES - 1);
            end else begin
              op_q    <= (data_i == CMD_SUSP) ? OP_SUSP : OP_ERS;
              ptr_q   <= '0;
              phase_q <= 1'b0;
            end
          end else if (cnt_q == '0) begin
            op_q    <= OP_ERS;
            ptr_q   <= '0;
            phase_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        OP_ERS: begin
          if (stb && data_i == CMD_SUSP) begin
            op_q <= OP_SUSP;
          end else begin
            ptr_q <= ptr_q + 1'b1;
            if (&ptr_q) begin
              if (!phase_q) phase_q <= 1'b1;
              else          op_q    <= OP_IDLE;
            end
          end
        end
        OP_SUSP: if (stb && seq_q == SQ_RD && data_i == CMD_SECT) op_q <= OP_ERS;
        default: ;
      endcase

      if (stb && (op_q == OP_IDLE || op_q == OP_SUSP)) begin
        seq_q <= SQ_RD;
        unique case (seq_q)
          SQ_RD: if (is_a1 && data_i == CMD_U1) seq_q <= SQ_U1;
          SQ_U1: if (is_a2 && data_i == CMD_U2) seq_q <= SQ_U2;
          SQ_U2: begin
            if (is_a1 && data_i == CMD_PGM) seq_q <= SQ_PG;
            else if (is_a1 && data_i == CMD_ESET && op_q == OP_IDLE) seq_q <= SQ_E1;
            else if (is_a1 && data_i == CMD_BYP && op_q == OP_IDLE) seq_q <= SQ_BYP;
          end
          SQ_E1: if (is_a1 && data_i == CMD_U1) seq_q <= SQ_E2;
          SQ_E2: if (is_a2 && data_i == CMD_U2) seq_q <= SQ_E3;
          SQ_E3: begin
            if (is_a1 && data_i == CMD_CHIP) begin
              mask_q  <= ~prot_i;
              op_q    <= OP_ERS;
              ptr_q   <= '0;
              phase_q <= 1'b0;
            end else if (data_i == CMD_SECT) begin
              mask_q <= sel & ~prot_i;
              op_q   <= OP_EWIN;
              cnt_q  <= CW'(EWIN_CYCLES - 1);
            end
          end
          SQ_BYP: if (data_i == CMD_PGM) seq_q <= SQ_BPG;
          SQ_PG, SQ_BPG: begin
            if (seq_q == SQ_BPG) seq_q <= SQ_BYP;
            if (pgm_ok) begin
              pa_q  <= addr_i;
              pd_q  <= data_i;
              cnt_q <= CW'(PGM_CYCLES - 1);
              op_q  <= (op_q == OP_IDLE) ? OP_PGM : OP_SPGM;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    mem_we_o = 1'b0;
    mem_wa_o = ptr_q;
    mem_wd_o = phase_q ? 8'hFF : 8'h00;
    if (pgm_done) begin
      mem_we_o = 1'b1;
      mem_wa_o = pa_q;
      mem_wd_o = pgm_old_i & pd_q;
    end else if (op_q == OP_ERS) begin
      mem_we_o = mask_q[sweep_sect_i];
    end
  end

  assign op_o     = op_q;
  assign mask_o   = mask_q;
  assign pgm_d7_o = pd_q[7];
  assign pa_o     = pa_q;
  assign ptr_o    = ptr_q;

  AST_LOWV_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lowv_i && wr_stb_i) |=> ($stable(seq_q) && $stable(mask_q))); // R9
  AST_PGM_UNPROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(op_q) == OP_IDLE || $past(op_q) == OP_SUSP) &&
     (op_q == OP_PGM || op_q == OP_SPGM)) |-> !$past(prot_i[sect_i])); // R8
  AST_ERASE_SKIPS_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_ERS) |-> ((mask_q & prot_i) == '0)); // R8
  AST_SUSP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_SUSP && $past(op_q) == OP_SUSP) |-> ($stable(ptr_q) && $stable(phase_q))); // R10
endmodule

// File: rtl/flash_status.sv
module flash_status
  import flash_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic             rd_end_i,
  input  op_e              op_i,
  input  logic [NSECT-1:0] mask_i,
  input  logic [3:0]       sect_i,
  input  logic             pgm_d7_i,
  input  logic [7:0]       arr_i,
  output logic [7:0]       data_o
);
  logic tog_q, busy;

  assign busy = op_i == OP_PGM || op_i == OP_SPGM || op_i == OP_EWIN || op_i == OP_ERS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tog_q <= 1'b0;
    else if (rd_end_i && busy)  tog_q <= ~tog_q;
  end

  always_comb begin
    data_o = 8'h00;
    if (rd_en_i) begin
      unique case (op_i)
        OP_PGM, OP_SPGM: data_o = {~pgm_d7_i, tog_q, 6'b0};
        OP_EWIN, OP_ERS: data_o = {1'b0, tog_q, 6'b0};
        OP_SUSP:         data_o = mask_i[sect_i] ? {1'b1, tog_q, 6'b0} : arr_i;
        default:         data_o = arr_i;
      endcase
    end
  end

  AST_TOG_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_end_i && busy) |=> (tog_q != $past(tog_q))); // R3
  AST_TOG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_end_i && !busy) |=> $stable(tog_q)); // R10
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_pkg::*;
#(
  parameter int UNIT_BYTES  = 32,
  parameter int PGM_CYCLES  = 20,
  parameter int EWIN_CYCLES = 64,
  localparam int AW    = $clog2(UNIT_BYTES) + 6,
  localparam int DEPTH = UNIT_BYTES * 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             we_ni,
  input  logic             oe_ni,
  input  logic             lowv_i,
  input  logic [NSECT-1:0] prot_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       data_i,
  output logic [7:0]       data_o
);
  logic [7:0]       mem [DEPTH];
  logic             wr_stb, rd_end, mem_we, pgm_d7;
  logic [3:0]       host_sect, sweep_sect;
  logic [AW-1:0]    pa, ptr, mem_wa;
  logic [7:0]       mem_wd;
  logic [NSECT-1:0] mask;
  op_e              op;

  flash_bus_sync u_sync (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni,
    .wr_stb_o(wr_stb), .rd_end_o(rd_end)
  );

  flash_sector_map #(.UNIT_BYTES(UNIT_BYTES)) u_map_host (
    .addr_i(addr_i), .sect_o(host_sect)
  );

  flash_sector_map #(.UNIT_BYTES(UNIT_BYTES)) u_map_sweep (
    .addr_i(ptr), .sect_o(sweep_sect)
  );

  flash_cmd_fsm #(
    .UNIT_BYTES(UNIT_BYTES), .PGM_CYCLES(PGM_CYCLES), .EWIN_CYCLES(EWIN_CYCLES)
  ) u_fsm (
    .clk_i, .rst_ni,
    .wr_stb_i(wr_stb), .lowv_i, .addr_i, .data_i,
    .sect_i(host_sect), .sweep_sect_i(sweep_sect), .prot_i,
    .pgm_old_i(mem[pa]),
    .op_o(op), .mask_o(mask), .pgm_d7_o(pgm_d7), .pa_o(pa), .ptr_o(ptr),
    .mem_we_o(mem_we), .mem_wa_o(mem_wa), .mem_wd_o(mem_wd)
  );

  flash_status u_stat (
    .clk_i, .rst_ni,
    .rd_en_i(~ce_ni & ~oe_ni), .rd_end_i(rd_end),
    .op_i(op), .mask_i(mask), .sect_i(host_sect), .pgm_d7_i(pgm_d7),
    .arr_i(mem[addr_i]), .data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (mem_we) begin
      mem[mem_wa] <= mem_wd;
    end
  end

  AST_PGM_CLEARS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && (op == OP_PGM || op == OP_SPGM)) |=> ((mem[$past(mem_wa)] & ~$past(mem[mem_wa])) == 8'h00)); // R2
endmodule

// File: tb/sim_flash_cmd_top.sv
module sim_flash_cmd_top;
  localparam int UNIT  = 32;
  localparam int PGM   = 20;
  localparam int EWIN  = 64;
  localparam int DEPTH = UNIT * 64;
  localparam int ERS_WAIT = 2 * DEPTH + EWIN + 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lowv = 1'b0;
  logic [10:0] prot = '0;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0, dout;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] mm [DEPTH];

  always #5 clk = ~clk;

  flash_cmd_top #(.UNIT_BYTES(UNIT), .PGM_CYCLES(PGM), .EWIN_CYCLES(EWIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .lowv_i(lowv), .prot_i(prot), .addr_i(addr), .data_i(din), .data_o(dout)
  );

  function automatic int sect_of(input int a);
    int u = a / UNIT;
    if (u < 56) return u / 8;
    if (u < 60) return 7;
    if (u == 60) return 8;
    if (u == 61) return 9;
    return 10;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 11'(a); din = 8'(d); ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = 11'(a); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); d = dout;
    oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock;
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  task automatic pgm(input int a, input int d);
    unlock(); wr(12'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre;
    unlock(); wr(12'h555, 8'h80); unlock();
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_mem(input string tag, input int a);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, mm[a]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s1, s2;
    int a, d, bad;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) mm[i] = 8'hFF;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk_mem("R1 addr0", 0);
    chk_mem("R1 addr top", DEPTH - 1);
    rd(5, s1); rd(5, s2);
    chk("R1 no toggle", s1 ^ s2, 0);

    // R2/R3 directed program
    pgm(12'h100, 8'h5A);
    rd(12'h100, s1); rd(12'h100, s2);
    chk("R3 pgm dq7", s1[7], 1);
    chk("R3 pgm low bits", s1[5:0], 0);
    chk("R3 pgm toggle", s1[6] ^ s2[6], 1);
    wait_cyc(PGM + 10);
    mm[12'h100] = 8'h5A;
    chk_mem("R2 program", 12'h100);
    rd(12'h100, s1); rd(12'h100, s2);
    chk("R3 done no toggle", s1 ^ s2, 0);
    pgm(12'h100, 8'hF0);
    wait_cyc(PGM + 10);
    mm[12'h100] = mm[12'h100] & 8'hF0;
    chk_mem("R2 and-only", 12'h100);

    // R2 random programs
    for (int k = 0; k < 12; k++) begin
      a = int'($urandom % DEPTH);
      d = int'($urandom % 256);
      pgm(a, d);
      wait_cyc(PGM + 10);
      mm[a] = mm[a] & 8'(d);
      chk("R2 random program", 0, 0);
      chk_mem("R2 random readback", a);
    end

    // R11 broken sequences
    wr(12'h555, 8'hAA); wr(12'h123, 8'h00); wr(12'h555, 8'hA0); wr(12'h200, 8'h00);
    wait_cyc(PGM + 10);
    chk_mem("R11 broken unlock", 12'h200);
    unlock(); wr(12'h555, 8'h77); wr(12'h201, 8'h00);
    wait_cyc(PGM + 10);
    chk_mem("R11 bad command", 12'h201);

    // R9 low supply
    lowv = 1'b1;
    pgm(12'h300, 8'h00);
    lowv = 1'b0;
    rd(12'h300, s1);
    chk("R9 no busy", s1, mm[12'h300]);
    wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h300, 8'h00);
    wait_cyc(PGM + 10);
    chk_mem("R9 sequence not advanced", 12'h300);

    // R4 bypass
    unlock(); wr(12'h555, 8'h20);
    for (int k = 0; k < 3; k++) begin
      wr(12'h7F0 + k, 8'hA0);
      wr(12'h010 + k, 8'h0F << k);
      wait_cyc(PGM + 10);
      mm[12'h010 + k] = mm[12'h010 + k] & 8'(8'h0F << k);
      chk_mem("R4 bypass program", 12'h010 + k);
    end
    wr(0, 8'h00);
    wr(0, 8'hA0); wr(12'h020, 8'h00);
    wait_cyc(PGM + 10);
    chk_mem("R4 bypass exit", 12'h020);

    // protected sectors get content, then lock 3 and 9
    pgm(800, 8'h12);  wait_cyc(PGM + 10); mm[800]  = mm[800]  & 8'h12;
    pgm(1960, 8'h34); wait_cyc(PGM + 10); mm[1960] = mm[1960] & 8'h34;
    prot = 11'b000_0000_1000 | 11'b010_0000_0000;
    pgm(810, 8'h00);
    rd(810, s1); rd(810, s2);
    chk("R8 protected no busy", s1, mm[810]);
    chk("R8 protected stable", s1 ^ s2, 0);

    // R5/R6 sector map edges and queued sector erase
    pgm(1919, 8'h11); wait_cyc(PGM + 10); mm[1919] = mm[1919] & 8'h11;
    pgm(1920, 8'h22); wait_cyc(PGM + 10); mm[1920] = mm[1920] & 8'h22;
    pgm(1984, 8'h33); wait_cyc(PGM + 10); mm[1984] = mm[1984] & 8'h33;
    pgm(2047, 8'h44); wait_cyc(PGM + 10); mm[2047] = mm[2047] & 8'h44;
    erase_pre(); wr(1920, 8'h30); wr(1984, 8'h30);
    rd(1919, s1);
    chk("R3 erase dq7", s1[7], 0);
    wait_cyc(ERS_WAIT);
    for (int i = 0; i < DEPTH; i++)
      if (sect_of(i) == 8 || sect_of(i) == 10) mm[i] = 8'hFF;
    chk_mem("R5 sector7 last byte kept", 1919);
    chk_mem("R6 sector8 first byte", 1920);
    chk_mem("R6 queued sector10", 1984);
    chk_mem("R5 top byte in sector10", 2047);
    chk_mem("R8 sector9 kept", 1960);

    // R10 suspend / resume
    pgm(12'h040, 8'h81); wait_cyc(PGM + 10); mm[12'h040] = mm[12'h040] & 8'h81;
    pgm(12'h410, 8'h66); wait_cyc(PGM + 10); mm[12'h410] = mm[12'h410] & 8'h66;
    erase_pre(); wr(12'h410, 8'h30);
    wait_cyc(EWIN + 40);
    wr(0, 8'hB0);
    wait_cyc(4);
    chk_mem("R10 read unselected", 12'h040);
    rd(12'h410, s1); rd(12'h410, s2);
    chk("R10 selected status", s1 & 8'hBF, 8'h80);
    chk("R10 selected no toggle", s1 ^ s2, 0);
    pgm(12'h050, 8'h33);
    wait_cyc(PGM + 10);
    mm[12'h050] = mm[12'h050] & 8'h33;
    chk_mem("R10 program during suspend", 12'h050);
    wr(0, 8'h30);
    wait_cyc(ERS_WAIT);
    for (int i = 0; i < DEPTH; i++) if (sect_of(i) == 4) mm[i] = 8'hFF;
    chk_mem("R10 resumed erase", 12'h410);
    chk_mem("R10 unselected kept", 12'h040);

    // R7 chip erase, protected sectors kept
    erase_pre(); wr(12'h555, 8'h10);
    wait_cyc(2 * DEPTH + 200);
    for (int i = 0; i < DEPTH; i++)
      if (!prot[sect_of(i)]) mm[i] = 8'hFF;
    chk_mem("R7 chip erase", 12'h100);
    chk_mem("R8 chip erase skips sector3", 800);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, s1);
      if (s1 != mm[i]) bad++;
    end
    chk("R7 full array compare", bad, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule